// File: doc/BRIEF.md
# Partitioned Near-Memory Line Cache Controller

This controller places a small, fast near memory in front of a large far memory. Requesters see a single physical address space of 64-byte lines. Ordinary addresses reach far memory through a direct-mapped cache held in near memory. A second address window reaches the part of near memory that is not used as cache. Every near-memory entry carries its own valid flag, dirty flag and tag beside the line data. One near-memory read therefore settles hit or miss and also delivers the data.

The split of near memory is chosen before boot. It can give the whole near memory to the cache, half of it, a quarter of it, or none of it. The cache takes the lowest near-memory entries. The remaining entries form the addressable window. The controller works on one request at a time: from acceptance until the response it holds the requester off. This covers a miss that writes back a dirty victim, fills from far memory and writes the new entry. Writes carry a per-byte enable.

Top module: `mcache_top`

## Requirements
- R1: `req_ready` stays low until the boot-done input has been seen high. After that it is high only while no request is in progress. Once a request is accepted, `req_ready` stays low until `resp_valid` pulses, and it returns high in the cycle after that pulse.
- R2: The partition code is 0 for all cache, 1 for half, 2 for a quarter and 3 for no cache, and reset selects code 0. The code is written through `cfg_we` only while boot-done is low and has never been high since reset. Writes made later change nothing until the next reset.
- R3: A read of any mapped line returns the bytes most recently written to that line. Bytes whose enable was low keep their earlier value, in every partition mode.
- R4: A cached line is found at entry index (line address mod cache lines). While it stays resident, a repeated read or a write to it causes no far-memory traffic.
- R5: On a miss, if the resident entry is valid and dirty, it is written to far memory at its own line address before the new line is fetched.
- R6: A write miss fetches the line from far memory, merges the enabled bytes into it and keeps the result dirty in near memory. No far-memory write happens at that time.
- R7: A miss that replaces a clean or invalid entry makes one far read and no far write.
- R8: When the top address bit is 1, the low address bits give a window offset. If that offset is below the window size (near lines minus cache lines), the request goes to near-memory index (cache lines + offset) and causes no far traffic.
- R9: A window offset at or above the window size is unmapped. Reads of it return zero, writes to it are dropped, and neither memory is accessed. In all-cache mode the whole window is unmapped.
- R10: In no-cache mode, every far-space access goes to far memory. A read makes one far read. A write makes one far read followed by one far write of the merged line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Partition code write strobe |
| cfg_mode | input | 2 | Partition code |
| boot_done | input | 1 | Boot complete; locks the partition |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | FAR_AW+1 | Line address; top bit selects the near window |
| req_wdata | input | 8*LINE_BYTES | Write line |
| req_be | input | LINE_BYTES | Per-byte write enable |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 8*LINE_BYTES | Read line |
| nm_req | output | 1 | Near-memory access strobe |
| nm_we | output | 1 | Near-memory write |
| nm_idx | output | NEAR_AW | Near-memory entry index |
| nm_wdata | output | 8*LINE_BYTES+FAR_AW+2 | Entry {valid, dirty, tag, data} |
| nm_rvalid | input | 1 | Near-memory read data valid |
| nm_rdata | input | 8*LINE_BYTES+FAR_AW+2 | Near-memory read entry |
| fm_req | output | 1 | Far-memory access strobe |
| fm_we | output | 1 | Far-memory write |
| fm_addr | output | FAR_AW | Far-memory line address |
| fm_wdata | output | 8*LINE_BYTES | Far-memory write line |
| fm_rvalid | input | 1 | Far-memory read data valid |
| fm_rdata | input | 8*LINE_BYTES | Far-memory read line |

## Verification
The partition code runs through all four values, and each is followed by directed sequences and then by random traffic. The directed sequences are a repeated read, a dirty conflict, a write miss and a clean conflict. The far read and write counts, together with the written-back address and data, separate a hit from a miss and a dirty eviction from a clean one. They also expose a mode change that should have been ignored. Random reads and partial writes use a few conflicting lines and offsets near the window boundary. They are compared with a flat reference image, which catches merge, index and window-size faults. Near-memory index and access counts on window traffic show whether the window sits above the cache region and whether unmapped offsets touch memory.

// File: rtl/mcache_pkg.sv
package mcache_pkg;
   typedef enum logic [1:0] {
      MODE_ALL     = 2'd0,
      MODE_HALF    = 2'd1,
      MODE_QUARTER = 2'd2,
      MODE_NONE    = 2'd3
   } part_mode_e;

   typedef enum logic [1:0] {
      RT_CACHED,
      RT_UNCACHED,
      RT_WINDOW,
      RT_UNMAPPED
   } route_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_NRD,
      ST_NWAIT,
      ST_WBACK,
      ST_FRD,
      ST_FWAIT,
      ST_NWR,
      ST_FWR,
      ST_RESP
   } state_e;
endpackage

// File: rtl/mcache_mode.sv
module mcache_mode
   import mcache_pkg::*;
#(
   parameter int NEAR_AW = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_mode,
   input  logic               boot_done,
   output part_mode_e         mode_o,
   output logic               locked_o,
   output logic [NEAR_AW:0]   cache_lines_o,
   output logic [NEAR_AW:0]   flat_lines_o
);
   localparam logic [NEAR_AW:0] TOTAL   = {1'b1, {NEAR_AW{1'b0}}};
   localparam logic [NEAR_AW:0] HALF    = TOTAL >> 1;
   localparam logic [NEAR_AW:0] QUARTER = TOTAL >> 2;

   generate
      if (NEAR_AW < 2) begin : g_bad_depth
         $error("mcache_mode: NEAR_AW must be at least 2");
      end
   endgenerate

   part_mode_e mode_q;
   logic       locked_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= MODE_ALL;
         locked_q <= 1'b0;
      end else begin
         if (boot_done)
            locked_q <= 1'b1;
         if (cfg_we && !boot_done && !locked_q)
            mode_q <= part_mode_e'(cfg_mode);
      end
   end

   always_comb begin
      case (mode_q)
         MODE_ALL:     cache_lines_o = TOTAL;
         MODE_HALF:    cache_lines_o = HALF;
         MODE_QUARTER: cache_lines_o = QUARTER;
         default:      cache_lines_o = '0;
      endcase
      flat_lines_o = TOTAL - cache_lines_o;
   end

   assign mode_o   = mode_q;
   assign locked_o = locked_q;
endmodule

// File: rtl/mcache_route.sv
module mcache_route
   import mcache_pkg::*;
#(
   parameter int FAR_AW  = 10,
   parameter int NEAR_AW = 6
) (
   input  logic [FAR_AW:0]    addr_i,
   input  logic [NEAR_AW:0]   cache_lines_i,
   input  logic [NEAR_AW:0]   flat_lines_i,
   output route_e             route_o,
   output logic [NEAR_AW-1:0] idx_o,
   output logic [FAR_AW-1:0]  tag_o
);
   generate
      if (FAR_AW < NEAR_AW) begin : g_bad_span
         $error("mcache_route: far space must be at least as large as near memory");
      end
   endgenerate

   logic [FAR_AW-1:0]  off;
   logic [FAR_AW:0]    off_ext;
   logic [FAR_AW:0]    flat_ext;
   logic [NEAR_AW-1:0] set_mask;

   assign off      = addr_i[FAR_AW-1:0];
   assign off_ext  = {1'b0, off};
   assign flat_ext = (FAR_AW+1)'(flat_lines_i);
   assign set_mask = NEAR_AW'(cache_lines_i - {{NEAR_AW{1'b0}}, 1'b1});

   always_comb begin
      tag_o = off;
      idx_o = '0;
      if (addr_i[FAR_AW]) begin
         if (off_ext < flat_ext) begin
            route_o = RT_WINDOW;
            idx_o   = cache_lines_i[NEAR_AW-1:0] + off[NEAR_AW-1:0];
         end else begin
            route_o = RT_UNMAPPED;
         end
      end else if (cache_lines_i == '0) begin
         route_o = RT_UNCACHED;
      end else begin
         route_o = RT_CACHED;
         idx_o   = off[NEAR_AW-1:0] & set_mask;
      end
   end
endmodule

// File: rtl/mcache_merge.sv
module mcache_merge #(
   parameter int LINE_BYTES = 64,
   localparam int DATA_W = 8 * LINE_BYTES
) (
   input  logic [DATA_W-1:0]     base_i,
   input  logic [DATA_W-1:0]     upd_i,
   input  logic [LINE_BYTES-1:0] be_i,
   output logic [DATA_W-1:0]     out_o
);
   generate
      for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
         assign out_o[b*8 +: 8] = be_i[b] ? upd_i[b*8 +: 8] : base_i[b*8 +: 8];
      end
   endgenerate
endmodule

// File: rtl/mcache_ctrl.sv
module mcache_ctrl
   import mcache_pkg::*;
#(
   parameter int FAR_AW     = 10,
   parameter int NEAR_AW    = 6,
   parameter int LINE_BYTES = 64,
   localparam int DATA_W = 8 * LINE_BYTES,
   localparam int ENT_W  = DATA_W + FAR_AW + 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  locked_i,
   input  logic                  req_valid_i,
   output logic                  req_ready_o,
   input  logic                  req_write_i,
   input  logic [DATA_W-1:0]     req_wdata_i,
   input  logic [LINE_BYTES-1:0] req_be_i,
   input  route_e                route_i,
   input  logic [NEAR_AW-1:0]    idx_i,
   input  logic [FAR_AW-1:0]     tag_i,
   output logic                  resp_valid_o,
   output logic [DATA_W-1:0]     resp_rdata_o,
   output logic                  nm_req_o,
   output logic                  nm_we_o,
   output logic [NEAR_AW-1:0]    nm_idx_o,
   output logic [ENT_W-1:0]      nm_wdata_o,
   input  logic                  nm_rvalid_i,
   input  logic [ENT_W-1:0]      nm_rdata_i,
   output logic                  fm_req_o,
   output logic                  fm_we_o,
   output logic [FAR_AW-1:0]     fm_addr_o,
   output logic [DATA_W-1:0]     fm_wdata_o,
   input  logic                  fm_rvalid_i,
   input  logic [DATA_W-1:0]     fm_rdata_i
);
   state_e                st_q;
   route_e                rt_q;
   logic [NEAR_AW-1:0]    idx_q;
   logic [FAR_AW-1:0]     tag_q;
   logic [FAR_AW-1:0]     vic_q;
   logic                  wr_q;
   logic [DATA_W-1:0]     wdata_q;
   logic [LINE_BYTES-1:0] be_q;
   logic [DATA_W-1:0]     line_q;

   logic [DATA_W-1:0]     src;
   logic [DATA_W-1:0]     merged;
   logic [DATA_W-1:0]     fill;
   logic                  ent_valid;
   logic                  ent_dirty;
   logic [FAR_AW-1:0]     ent_tag;
   logic                  hit;

   assign src       = (st_q == ST_NWAIT) ? nm_rdata_i[DATA_W-1:0] : fm_rdata_i;
   assign ent_valid = nm_rdata_i[ENT_W-1];
   assign ent_dirty = nm_rdata_i[ENT_W-2];
   assign ent_tag   = nm_rdata_i[DATA_W +: FAR_AW];
   assign hit       = ent_valid && (ent_tag == tag_q);
   assign fill      = wr_q ? merged : src;

   mcache_merge #(.LINE_BYTES(LINE_BYTES)) u_merge (
      .base_i (src),
      .upd_i  (wdata_q),
      .be_i   (be_q),
      .out_o  (merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         rt_q    <= RT_UNMAPPED;
         idx_q   <= '0;
         tag_q   <= '0;
         vic_q   <= '0;
         wr_q    <= 1'b0;
         wdata_q <= '0;
         be_q    <= '0;
         line_q  <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (req_valid_i && req_ready_o) begin
                  rt_q    <= route_i;
                  idx_q   <= idx_i;
                  tag_q   <= tag_i;
                  wr_q    <= req_write_i;
                  wdata_q <= req_wdata_i;
                  be_q    <= req_be_i;
                  case (route_i)
                     RT_UNMAPPED: begin
                        line_q <= '0;
                        st_q   <= ST_RESP;
                     end
                     RT_UNCACHED: st_q <= ST_FRD;
                     default:     st_q <= ST_NRD;
                  endcase
               end
            end
            ST_NRD: st_q <= ST_NWAIT;
            ST_NWAIT: begin
               if (nm_rvalid_i) begin
                  if (rt_q == RT_WINDOW || hit) begin
                     line_q <= fill;
                     st_q   <= wr_q ? ST_NWR : ST_RESP;
                  end else begin
                     line_q <= nm_rdata_i[DATA_W-1:0];
                     vic_q  <= ent_tag;
                     st_q   <= (ent_valid && ent_dirty) ? ST_WBACK : ST_FRD;
                  end
               end
            end
            ST_WBACK: st_q <= ST_FRD;
            ST_FRD:   st_q <= ST_FWAIT;
            ST_FWAIT: begin
               if (fm_rvalid_i) begin
                  line_q <= fill;
                  if (rt_q == RT_CACHED)
                     st_q <= ST_NWR;
                  else
                     st_q <= wr_q ? ST_FWR : ST_RESP;
               end
            end
            ST_NWR:  st_q <= ST_RESP;
            ST_FWR:  st_q <= ST_RESP;
            ST_RESP: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready_o  = (st_q == ST_IDLE) && locked_i;
      resp_valid_o = (st_q == ST_RESP);
      resp_rdata_o = line_q;
      nm_req_o     = (st_q == ST_NRD) || (st_q == ST_NWR);
      nm_we_o      = (st_q == ST_NWR);
      nm_idx_o     = idx_q;
      if (rt_q == RT_CACHED)
         nm_wdata_o = {1'b1, wr_q, tag_q, line_q};
      else
         nm_wdata_o = {2'b00, {FAR_AW{1'b0}}, line_q};
      fm_req_o     = (st_q == ST_WBACK) || (st_q == ST_FRD) || (st_q == ST_FWR);
      fm_we_o      = (st_q == ST_WBACK) || (st_q == ST_FWR);
      fm_addr_o    = (st_q == ST_WBACK) ? vic_q : tag_q;
      fm_wdata_o   = line_q;
   end
endmodule

// File: rtl/mcache_top.sv
module mcache_top
   import mcache_pkg::*;
#(
   parameter int FAR_AW     = 10,
   parameter int NEAR_AW    = 6,
   parameter int LINE_BYTES = 64,
   localparam int DATA_W = 8 * LINE_BYTES,
   localparam int PA_W   = FAR_AW + 1,
   localparam int ENT_W  = DATA_W + FAR_AW + 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [1:0]            cfg_mode,
   input  logic                  boot_done,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_write,
   input  logic [PA_W-1:0]       req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic [LINE_BYTES-1:0] req_be,
   output logic                  resp_valid,
   output logic [DATA_W-1:0]     resp_rdata,
   output logic                  nm_req,
   output logic                  nm_we,
   output logic [NEAR_AW-1:0]    nm_idx,
   output logic [ENT_W-1:0]      nm_wdata,
   input  logic                  nm_rvalid,
   input  logic [ENT_W-1:0]      nm_rdata,
   output logic                  fm_req,
   output logic                  fm_we,
   output logic [FAR_AW-1:0]     fm_addr,
   output logic [DATA_W-1:0]     fm_wdata,
   input  logic                  fm_rvalid,
   input  logic [DATA_W-1:0]     fm_rdata
);
   generate
      if (LINE_BYTES < 1) begin : g_bad_line
         $error("mcache_top: LINE_BYTES must be positive");
      end
   endgenerate

   part_mode_e         part_mode;
   logic               boot_locked;
   logic [NEAR_AW:0]   cache_lines;
   logic [NEAR_AW:0]   flat_lines;
   route_e             route;
   logic [NEAR_AW-1:0] route_idx;
   logic [FAR_AW-1:0]  route_tag;

   mcache_mode #(.NEAR_AW(NEAR_AW)) u_mode (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_we        (cfg_we),
      .cfg_mode      (cfg_mode),
      .boot_done     (boot_done),
      .mode_o        (part_mode),
      .locked_o      (boot_locked),
      .cache_lines_o (cache_lines),
      .flat_lines_o  (flat_lines)
   );

   mcache_route #(.FAR_AW(FAR_AW), .NEAR_AW(NEAR_AW)) u_route (
      .addr_i        (req_addr),
      .cache_lines_i (cache_lines),
      .flat_lines_i  (flat_lines),
      .route_o       (route),
      .idx_o         (route_idx),
      .tag_o         (route_tag)
   );

   mcache_ctrl #(.FAR_AW(FAR_AW), .NEAR_AW(NEAR_AW), .LINE_BYTES(LINE_BYTES)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .locked_i     (boot_locked),
      .req_valid_i  (req_valid),
      .req_ready_o  (req_ready),
      .req_write_i  (req_write),
      .req_wdata_i  (req_wdata),
      .req_be_i     (req_be),
      .route_i      (route),
      .idx_i        (route_idx),
      .tag_i        (route_tag),
      .resp_valid_o (resp_valid),
      .resp_rdata_o (resp_rdata),
      .nm_req_o     (nm_req),
      .nm_we_o      (nm_we),
      .nm_idx_o     (nm_idx),
      .nm_wdata_o   (nm_wdata),
      .nm_rvalid_i  (nm_rvalid),
      .nm_rdata_i   (nm_rdata),
      .fm_req_o     (fm_req),
      .fm_we_o      (fm_we),
      .fm_addr_o    (fm_addr),
      .fm_wdata_o   (fm_wdata),
      .fm_rvalid_i  (fm_rvalid),
      .fm_rdata_i   (fm_rdata)
   );
endmodule

module mcache_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       locked,
   input logic [1:0] mode,
   input logic       req_valid,
   input logic       req_ready,
   input logic       resp_valid,
   input logic       nm_req,
   input logic       fm_req
);
   // R1
   no_accept_before_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> !req_ready);
   // R1
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   // R1
   ready_after_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> req_ready);
   // R1
   one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({nm_req, fm_req, resp_valid}));
   // R2
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);
   // R2
   mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(mode));
endmodule

bind mcache_top mcache_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .locked     (boot_locked),
   .mode       (part_mode),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .resp_valid (resp_valid),
   .nm_req     (nm_req),
   .fm_req     (fm_req)
);

// File: tb/mcache_top_tb.sv
`timescale 1ns/1ps
module mcache_top_tb;
   localparam int NA = 6;
   localparam int FA = 10;
   localparam int BY = 64;
   localparam int DW = 8 * BY;
   localparam int EW = DW + FA + 2;
   localparam int NL = 1 << NA;
   localparam int FL = 1 << FA;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_mode = 2'd0;
   logic          boot_done = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [FA:0]   req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [BY-1:0] req_be = '0;
   logic          resp_valid;
   logic [DW-1:0] resp_rdata;
   logic          nm_req, nm_we;
   logic [NA-1:0] nm_idx;
   logic [EW-1:0] nm_wdata;
   logic          nm_rvalid;
   logic [EW-1:0] nm_rdata;
   logic          fm_req, fm_we;
   logic [FA-1:0] fm_addr;
   logic [DW-1:0] fm_wdata;
   logic          fm_rvalid;
   logic [DW-1:0] fm_rdata;

   always #10 clk = ~clk;

   mcache_top #(.FAR_AW(FA), .NEAR_AW(NA), .LINE_BYTES(BY)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .boot_done(boot_done),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_be(req_be), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
      .nm_req(nm_req), .nm_we(nm_we), .nm_idx(nm_idx), .nm_wdata(nm_wdata),
      .nm_rvalid(nm_rvalid), .nm_rdata(nm_rdata),
      .fm_req(fm_req), .fm_we(fm_we), .fm_addr(fm_addr), .fm_wdata(fm_wdata),
      .fm_rvalid(fm_rvalid), .fm_rdata(fm_rdata)
   );

   function automatic logic [DW-1:0] far_init(int i);
      logic [DW-1:0] v;
      for (int k = 0; k < DW / 32; k++)
         v[k*32 +: 32] = (i * 32'h9E3779B1) ^ (k << 20) ^ 32'h5A5A0000;
      return v;
   endfunction

   // memory models
   logic          clr_mem = 1'b0;
   logic [EW-1:0] near_m [NL];
   logic [DW-1:0] far_m [FL];
   int            n_cnt = 0, f_cnt = 0;
   logic [EW-1:0] n_hold;
   logic [DW-1:0] f_hold;
   int            nm_acc = 0, fr_acc = 0, fw_acc = 0;
   logic [NA-1:0] last_nidx = '0;
   logic [FA-1:0] last_fwa = '0;
   logic [DW-1:0] last_fwd = '0;

   always @(posedge clk) begin
      nm_rvalid <= 1'b0;
      fm_rvalid <= 1'b0;
      if (clr_mem) begin
         for (int i = 0; i < NL; i++) near_m[i] <= '0;
         for (int i = 0; i < FL; i++) far_m[i] <= far_init(i);
         n_cnt <= 0;
         f_cnt <= 0;
      end else begin
         if (n_cnt != 0) begin
            n_cnt <= n_cnt - 1;
            if (n_cnt == 1) begin
               nm_rvalid <= 1'b1;
               nm_rdata  <= n_hold;
            end
         end
         if (f_cnt != 0) begin
            f_cnt <= f_cnt - 1;
            if (f_cnt == 1) begin
               fm_rvalid <= 1'b1;
               fm_rdata  <= f_hold;
            end
         end
         if (nm_req) begin
            nm_acc    <= nm_acc + 1;
            last_nidx <= nm_idx;
            if (nm_we) near_m[nm_idx] <= nm_wdata;
            else begin
               n_hold <= near_m[nm_idx];
               n_cnt  <= 2;
            end
         end
         if (fm_req) begin
            if (fm_we) begin
               far_m[fm_addr] <= fm_wdata;
               fw_acc   <= fw_acc + 1;
               last_fwa <= fm_addr;
               last_fwd <= fm_wdata;
            end else begin
               f_hold <= far_m[fm_addr];
               f_cnt  <= 3;
               fr_acc <= fr_acc + 1;
            end
         end
      end
   end

   // reference image
   logic [DW-1:0] g_far [FL];
   logic [DW-1:0] g_flat [NL];
   int n_chk = 0, n_bad = 0;
   int cl = 0, fsz = 0;

   task automatic chk_line(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic chk_int(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] rand_line();
      logic [DW-1:0] v;
      for (int k = 0; k < DW / 32; k++) v[k*32 +: 32] = $urandom;
      return v;
   endfunction

   function automatic logic [DW-1:0] merge(logic [DW-1:0] o, logic [DW-1:0] n, logic [BY-1:0] be);
      logic [DW-1:0] r = o;
      for (int b = 0; b < BY; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
      return r;
   endfunction

   function automatic logic [DW-1:0] g_read(logic [FA:0] a);
      if (a[FA]) return (int'(a[FA-1:0]) < fsz) ? g_flat[a[NA-1:0]] : '0;
      return g_far[a[FA-1:0]];
   endfunction

   task automatic g_write(logic [FA:0] a, logic [DW-1:0] d, logic [BY-1:0] be);
      if (a[FA]) begin
         if (int'(a[FA-1:0]) < fsz) g_flat[a[NA-1:0]] = merge(g_flat[a[NA-1:0]], d, be);
      end else g_far[a[FA-1:0]] = merge(g_far[a[FA-1:0]], d, be);
   endtask

   task automatic do_req(bit wr, logic [FA:0] a, logic [DW-1:0] d, logic [BY-1:0] be,
                         output logic [DW-1:0] rd);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      @(negedge clk);
      req_valid = 1'b0;
      while (!resp_valid) @(negedge clk);
      rd = resp_rdata;
      if (wr) g_write(a, d, be);
   endtask

   task automatic rd_chk(string tag, logic [FA:0] a);
      logic [DW-1:0] r;
      do_req(1'b0, a, '0, '0, r);
      chk_line(tag, r, g_read(a));
   endtask

   function automatic logic [FA:0] win(int off);
      return {1'b1, FA'(off)};
   endfunction

   task automatic boot(int m);
      rst_n = 1'b0; clr_mem = 1'b1; cfg_we = 1'b0; boot_done = 1'b0;
      repeat (3) @(negedge clk);
      clr_mem = 1'b0;
      chk_int("R1 ready low in reset", int'(req_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_int("R1 ready low before boot", int'(req_ready), 0);
      if (m != 0) begin
         cfg_we = 1'b1; cfg_mode = 2'(m);
         @(negedge clk);
         cfg_we = 1'b0;
      end
      repeat (2) @(negedge clk);
      chk_int("R1 still held off before boot", int'(req_ready), 0);
      boot_done = 1'b1;
      @(negedge clk);
      cfg_we = 1'b1; cfg_mode = 2'(3 - m);
      @(negedge clk);
      cfg_we = 1'b0;
      chk_int("R1 ready after boot", int'(req_ready), 1);
      cl  = (m == 3) ? 0 : (NL >> m);
      fsz = NL - cl;
      for (int i = 0; i < FL; i++) g_far[i] = far_init(i);
      for (int i = 0; i < NL; i++) g_flat[i] = '0;
   endtask

   task automatic run_mode(int m);
      int fr0, fw0, nm0;
      logic [DW-1:0] r;
      boot(m);
      if (cl > 0) begin
         fr0 = fr_acc;
         rd_chk("R3 first read", 11'd5);
         chk_int("R7 cold miss far reads", fr_acc - fr0, 1);
         fr0 = fr_acc; fw0 = fw_acc;
         rd_chk("R4 repeat read data", 11'd5);
         chk_int("R4 R2 repeat read no far read", fr_acc - fr0, 0);
         do_req(1'b1, 11'd5, rand_line(), 64'h00FF_0000_F0F0_0001, r);
         chk_int("R4 write hit no far traffic", (fr_acc - fr0) + (fw_acc - fw0), 0);
         fw0 = fw_acc;
         rd_chk("R3 conflict read", 11'(5 + cl));
         chk_int("R5 dirty victim written", fw_acc - fw0, 1);
         chk_int("R5 victim address", int'(last_fwa), 5);
         chk_line("R5 victim data", last_fwd, g_far[5]);
         rd_chk("R3 evicted line reread", 11'd5);
         fr0 = fr_acc; fw0 = fw_acc;
         do_req(1'b1, 11'd9, rand_line(), 64'hFFFF_0000_0000_FF00, r);
         chk_int("R6 write miss fetch", fr_acc - fr0, 1);
         chk_int("R6 write miss no far write", fw_acc - fw0, 0);
         fw0 = fw_acc;
         rd_chk("R6 conflict after write miss", 11'(9 + cl));
         chk_int("R6 merged line written back", fw_acc - fw0, 1);
         chk_line("R6 written-back data", last_fwd, g_far[9]);
         fr0 = fr_acc; fw0 = fw_acc;
         rd_chk("R7 clean conflict data", 11'(9 + 2 * cl));
         chk_int("R7 clean victim no write", fw_acc - fw0, 0);
         chk_int("R7 clean victim one read", fr_acc - fr0, 1);
      end else begin
         fr0 = fr_acc;
         rd_chk("R10 uncached read", 11'd5);
         rd_chk("R10 uncached reread", 11'd5);
         chk_int("R10 every read goes far", fr_acc - fr0, 2);
         fr0 = fr_acc; fw0 = fw_acc;
         do_req(1'b1, 11'd7, rand_line(), 64'h0F0F_0F0F_0000_FFFF, r);
         chk_int("R10 write far read", fr_acc - fr0, 1);
         chk_int("R10 write far write", fw_acc - fw0, 1);
         chk_line("R10 far line merged", last_fwd, g_far[7]);
      end
      // window region
      if (fsz > 0) begin
         fr0 = fr_acc; fw0 = fw_acc; nm0 = nm_acc;
         do_req(1'b1, win(0), rand_line(), '1, r);
         rd_chk("R8 window low entry", win(0));
         chk_int("R8 window index", int'(last_nidx), cl);
         chk_int("R8 window near accesses", nm_acc - nm0, 3);
         do_req(1'b1, win(fsz - 1), rand_line(), 64'hAAAA_5555_0000_1234, r);
         rd_chk("R8 R3 window top entry", win(fsz - 1));
         chk_int("R8 window top index", int'(last_nidx), NL - 1);
         chk_int("R8 window no far traffic", (fr_acc - fr0) + (fw_acc - fw0), 0);
      end
      nm0 = nm_acc; fr0 = fr_acc; fw0 = fw_acc;
      do_req(1'b1, win(fsz), rand_line(), '1, r);
      do_req(1'b0, win(fsz), '0, '0, r);
      chk_line("R9 unmapped reads zero", r, '0);
      chk_int("R9 unmapped no traffic", (nm_acc - nm0) + (fr_acc - fr0) + (fw_acc - fw0), 0);
      // random traffic
      for (int n = 0; n < 250; n++) begin
         logic [FA:0] a;
         int sel = int'($urandom % 10);
         if (sel < 6) a = {1'b0, FA'(($urandom % 6) + cl * ($urandom % 3))};
         else if (sel < 7) a = {1'b0, FA'($urandom)};
         else a = win(int'($urandom % (fsz + 3)));
         if ($urandom % 2) do_req(1'b1, a, rand_line(), {$urandom, $urandom}, r);
         else rd_chk("R3 random read", a);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int m = 0; m < 4; m++) run_mode(m);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired R1 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule